// File: doc/BRIEF.md
# Byte-Serial Variable-Length Instruction Fetcher

This block sits in front of an execute stage and pulls instructions out of a byte-wide program memory. It fetches one byte at a time. It classifies the first byte (the opcode) into an operand format, and from that format it knows the instruction is 1 to 5 bytes long. It then fetches the remaining bytes and splits them into decoded fields: up to three register indices, a 16-bit value or address, a 24-bit address, and an 8-bit value or line index. Fields that the format does not use are driven to zero.

The memory port is a plain read strobe with an address. The byte comes back on the read-data input one clock after the strobe. Only one read is outstanding at a time.

The decoded bundle leaves on a valid/ready stream:
- Once `out_valid` rises, the bundle and `out_valid` stay fixed until the cycle in which `out_ready` is high.
- No memory read is issued while a bundle is waiting.
- After the handshake, fetching resumes at the byte that follows the instruction.

A one-cycle `redirect` pulse loads a new fetch address. It drops any half-assembled or waiting instruction and ignores the byte of a read already in flight.

Top module: `ifetch_top`

## Requirements
- R1: Instruction length follows the opcode class:
  - 1 byte: 0x00, 0x08, 0x12, 0x13, 0x21, 0x22, 0x25, 0x2F, 0x32–0x35.
  - 2 bytes: single-register opcodes 0x09, 0x0A, 0x0E–0x10, 0x14, 0x15, 0x26, 0x27, 0x44, 0x45, and the line-index opcode 0x2E.
  - 3 bytes: two-register opcodes 0x11, 0x23, 0x24, 0x28, 0x29, 0x3A–0x3D, 0x3F, 0x40; address-only opcodes 0x06, 0x07, 0x41, 0x42; and 0x43.
  - 4 bytes: three-register opcodes 0x01, 0x02, 0x0B, 0x0D, 0x16–0x18, 0x1F, 0x20, 0x46; register-plus-16-bit opcodes 0x03–0x05, 0x2A–0x2D, 0x36, 0x37; and 0x3E.
  - 5 bytes: compare-branch 0x19–0x1E and 24-bit memory 0x30, 0x31, 0x38, 0x39.
  - The length is reported on `out_len`.
- R2: Field placement, with multi-byte values taken high byte first:
  - Register-plus-16-bit: `out_ra` from byte 1, `out_imm16` = {byte 2, byte 3}.
  - Address-only: `out_imm16` = {byte 1, byte 2}.
  - Compare-branch: `out_ra` from byte 1, `out_rb` from byte 2, `out_imm16` = {byte 3, byte 4}.
  - 24-bit memory: `out_ra` from byte 1, `out_addr24` = {byte 2, byte 3, byte 4}.
  - 0x43: `out_ra` from byte 1, `out_byte8` = byte 2.
  - 0x2E: `out_byte8` = byte 1.
  - 0x3E: `out_byte8` = byte 1, `out_imm16` = {byte 2, byte 3}.
  - Register lists fill `out_ra`, `out_rb`, `out_rc` in byte order.
- R3: A register index is bits 3:0 of its operand byte; bits 7:4 have no effect on any output.
- R4: Opcode 0x0C and every opcode above 0x46 form a 1-byte instruction with `out_illegal` = 1. Every defined opcode gives `out_illegal` = 0.
- R5: `out_pc` is the address of the instruction's opcode byte. The next instruction starts at `out_pc + out_len`.
- R6: While `out_valid` = 1 and `out_ready` = 0, the bundle stays unchanged and `mem_rd_en` stays 0.
- R7: A `redirect` pulse clears `out_valid` in the next cycle. The next bundle is the instruction at `redirect_pc`, whatever was partly fetched before.
- R8: Each read strobe is followed by a cycle without one. The first read after a redirect uses `redirect_pc`.
- R9: Fields that the opcode's format does not use read as zero.
- R10: After reset, `out_valid` = 0 and the first read is issued at `RESET_PC` (0x0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Load new fetch address, discard current instruction |
| redirect_pc | input | 16 | New fetch address |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read byte, valid one cycle after the strobe |
| out_valid | output | 1 | Bundle valid |
| out_ready | input | 1 | Execute stage accepts the bundle |
| out_pc | output | 16 | Address of the opcode byte |
| out_op | output | 8 | Opcode |
| out_len | output | 3 | Instruction length in bytes |
| out_ra | output | 4 | First register index |
| out_rb | output | 4 | Second register index |
| out_rc | output | 4 | Third register index |
| out_imm16 | output | 16 | 16-bit value or address |
| out_addr24 | output | 24 | 24-bit address |
| out_byte8 | output | 8 | 8-bit value or line index |
| out_illegal | output | 1 | Undefined opcode |

## Verification
The bench walks a packed program that covers every length class and ends on undefined opcodes at both edges of the defined range. A wrong length would shift all the following `out_pc` values and misread later opcodes. Register bytes carry junk in their high nibble, so an index taken from the wrong bits shows up at once. While each bundle is held, the bench checks that it stays stable and that no read is issued; a design that keeps fetching would lose bytes. The bench also redirects mid-instruction and while a bundle waits. A design that keeps the stale partial bytes, or captures the in-flight byte, delivers a corrupted opcode or the wrong start address.

// File: rtl/ifetch_pkg.sv
`timescale 1ns/1ps
package ifetch_pkg;
  localparam int MAX_LEN = 5;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int BYTE_W  = 8;

  typedef enum logic [3:0] {
    FMT_NONE, FMT_R1, FMT_R2, FMT_R3, FMT_RI16, FMT_A16,
    FMT_RRA, FMT_RA24, FMT_RV8, FMT_LINE, FMT_LA16
  } fmt_e;

  typedef enum logic [1:0] {ST_ISSUE, ST_WAIT, ST_HOLD} st_e;

  function automatic logic [LEN_W-1:0] fmt_len(fmt_e f);
    case (f)
      FMT_R1, FMT_LINE:           fmt_len = LEN_W'(2);
      FMT_R2, FMT_A16, FMT_RV8:   fmt_len = LEN_W'(3);
      FMT_R3, FMT_RI16, FMT_LA16: fmt_len = LEN_W'(4);
      FMT_RRA, FMT_RA24:          fmt_len = LEN_W'(5);
      default:                    fmt_len = LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ifetch_optab.sv
`timescale 1ns/1ps
module ifetch_optab
  import ifetch_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output fmt_e              fmt,
  output logic              illegal
);
  always_comb begin
    illegal = 1'b0;
    case (op) inside
      8'h00, 8'h08, 8'h12, 8'h13, 8'h21, 8'h22, 8'h25, 8'h2F,
      [8'h32:8'h35]:                                   fmt = FMT_NONE;
      8'h09, 8'h0A, [8'h0E:8'h10], 8'h14, 8'h15, 8'h26,
      8'h27, 8'h44, 8'h45:                             fmt = FMT_R1;
      8'h11, 8'h23, 8'h24, 8'h28, 8'h29, [8'h3A:8'h3D],
      8'h3F, 8'h40:                                    fmt = FMT_R2;
      8'h01, 8'h02, 8'h0B, 8'h0D, [8'h16:8'h18], 8'h1F,
      8'h20, 8'h46:                                    fmt = FMT_R3;
      [8'h03:8'h05], [8'h2A:8'h2D], 8'h36, 8'h37:      fmt = FMT_RI16;
      8'h06, 8'h07, 8'h41, 8'h42:                      fmt = FMT_A16;
      [8'h19:8'h1E]:                                   fmt = FMT_RRA;
      8'h30, 8'h31, 8'h38, 8'h39:                      fmt = FMT_RA24;
      8'h43:                                           fmt = FMT_RV8;
      8'h2E:                                           fmt = FMT_LINE;
      8'h3E:                                           fmt = FMT_LA16;
      default: begin
        fmt     = FMT_NONE;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ifetch_fields.sv
`timescale 1ns/1ps
module ifetch_fields
  import ifetch_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  fmt_e                           fmt,
  input  logic [MAX_LEN-1:0][BYTE_W-1:0] byt,
  output logic [REG_W-1:0]               ra,
  output logic [REG_W-1:0]               rb,
  output logic [REG_W-1:0]               rc,
  output logic [2*BYTE_W-1:0]            imm16,
  output logic [3*BYTE_W-1:0]            addr24,
  output logic [BYTE_W-1:0]              byte8
);
  always_comb begin
    ra = '0; rb = '0; rc = '0; imm16 = '0; addr24 = '0; byte8 = '0;
    case (fmt)
      FMT_R1: ra = byt[1][REG_W-1:0];
      FMT_R2: begin
        ra = byt[1][REG_W-1:0];
        rb = byt[2][REG_W-1:0];
      end
      FMT_R3: begin
        ra = byt[1][REG_W-1:0];
        rb = byt[2][REG_W-1:0];
        rc = byt[3][REG_W-1:0];
      end
      FMT_RI16: begin
        ra    = byt[1][REG_W-1:0];
        imm16 = {byt[2], byt[3]};
      end
      FMT_A16: imm16 = {byt[1], byt[2]};
      FMT_RRA: begin
        ra    = byt[1][REG_W-1:0];
        rb    = byt[2][REG_W-1:0];
        imm16 = {byt[3], byt[4]};
      end
      FMT_RA24: begin
        ra     = byt[1][REG_W-1:0];
        addr24 = {byt[2], byt[3], byt[4]};
      end
      FMT_RV8: begin
        ra    = byt[1][REG_W-1:0];
        byte8 = byt[2];
      end
      FMT_LINE: byte8 = byt[1];
      FMT_LA16: begin
        byte8 = byt[1];
        imm16 = {byt[2], byt[3]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ifetch_top.sv
`timescale 1ns/1ps
module ifetch_top
  import ifetch_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          REG_W    = 4,
  parameter logic [15:0] RESET_PC = 16'h0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                redirect,
  input  logic [PC_W-1:0]     redirect_pc,
  output logic                mem_rd_en,
  output logic [PC_W-1:0]     mem_addr,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PC_W-1:0]     out_pc,
  output logic [BYTE_W-1:0]   out_op,
  output logic [LEN_W-1:0]    out_len,
  output logic [REG_W-1:0]    out_ra,
  output logic [REG_W-1:0]    out_rb,
  output logic [REG_W-1:0]    out_rc,
  output logic [2*BYTE_W-1:0] out_imm16,
  output logic [3*BYTE_W-1:0] out_addr24,
  output logic [BYTE_W-1:0]   out_byte8,
  output logic                out_illegal
);
  st_e                            st_q;
  logic [PC_W-1:0]                pc_q, ipc_q;
  logic [LEN_W-1:0]               cnt_q, len_q, cur_len;
  fmt_e                           fmt_q, new_fmt;
  logic                           ill_q, new_ill, capture, last;
  logic [MAX_LEN-1:0][BYTE_W-1:0] bytes_q;

  ifetch_optab u_tab (.op(mem_rdata), .fmt(new_fmt), .illegal(new_ill));

  assign capture = (st_q == ST_WAIT) && !redirect;
  assign cur_len = (cnt_q == '0) ? fmt_len(new_fmt) : len_q;
  assign last    = (cnt_q + LEN_W'(1)) == cur_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_ISSUE;
      pc_q  <= PC_W'(RESET_PC);
      ipc_q <= PC_W'(RESET_PC);
      cnt_q <= '0;
      len_q <= LEN_W'(1);
      fmt_q <= FMT_NONE;
      ill_q <= 1'b0;
    end else if (redirect) begin
      st_q  <= ST_ISSUE;
      pc_q  <= redirect_pc;
      ipc_q <= redirect_pc;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_ISSUE: begin
          pc_q <= pc_q + PC_W'(1);
          st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            fmt_q <= new_fmt;
            ill_q <= new_ill;
            len_q <= fmt_len(new_fmt);
          end
          cnt_q <= cnt_q + LEN_W'(1);
          st_q  <= last ? ST_HOLD : ST_ISSUE;
        end
        default: begin
          if (out_ready) begin
            cnt_q <= '0;
            ipc_q <= pc_q;
            st_q  <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        bytes_q[i] <= '0;
      else if (capture && cnt_q == LEN_W'(i))
        bytes_q[i] <= mem_rdata;
    end
  end

  ifetch_fields #(.REG_W(REG_W)) u_fields (
    .fmt(fmt_q), .byt(bytes_q), .ra(out_ra), .rb(out_rb), .rc(out_rc),
    .imm16(out_imm16), .addr24(out_addr24), .byte8(out_byte8)
  );

  assign mem_rd_en   = (st_q == ST_ISSUE) && !redirect;
  assign mem_addr    = pc_q;
  assign out_valid   = (st_q == ST_HOLD);
  assign out_pc      = ipc_q;
  assign out_op      = bytes_q[0];
  assign out_len     = len_q;
  assign out_illegal = ill_q;
endmodule

// File: rtl/ifetch_chk.sv
`timescale 1ns/1ps
module ifetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        redirect,
  input logic        mem_rd_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_pc,
  input logic [7:0]  out_op,
  input logic [2:0]  out_len,
  input logic        out_illegal
);
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd5));

  a_r4_illegal_short: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> out_len == 3'd1);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect) |=>
      (out_valid && $stable(out_op) && $stable(out_pc) && $stable(out_len)));

  a_r6_no_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_rd_en);

  a_r7_redirect_drop: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !out_valid);

  a_r8_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind ifetch_top ifetch_chk u_chk (.*);

// File: tb/ifetch_top_tb.sv
`timescale 1ns/1ps
module ifetch_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [15:0] redirect_pc = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_pc;
  logic [7:0]  out_op;
  logic [2:0]  out_len;
  logic [3:0]  out_ra, out_rb, out_rc;
  logic [15:0] out_imm16;
  logic [23:0] out_addr24;
  logic [7:0]  out_byte8;
  logic        out_illegal;
  logic [7:0]  mem [1024];
  int          checks = 0;
  int          errors = 0;

  typedef struct packed {
    logic [39:0] b;
    logic [2:0]  len;
    logic [3:0]  ra, rb, rc;
    logic [15:0] imm;
    logic [23:0] a24;
    logic [7:0]  b8;
    logic        ill;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{40'h01A3B4C500, 3'd4, 4'h3, 4'h4, 4'h5, 16'h0000, 24'h000000, 8'h00, 1'b0},
    '{40'h0000000000, 3'd1, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b0},
    '{40'h0572123400, 3'd4, 4'h2, 4'h0, 4'h0, 16'h1234, 24'h000000, 8'h00, 1'b0},
    '{40'h06ABCD0000, 3'd3, 4'h0, 4'h0, 4'h0, 16'hABCD, 24'h000000, 8'h00, 1'b0},
    '{40'h1981920F3C, 3'd5, 4'h1, 4'h2, 4'h0, 16'h0F3C, 24'h000000, 8'h00, 1'b0},
    '{40'h30070A0010, 3'd5, 4'h7, 4'h0, 4'h0, 16'h0000, 24'h0A0010, 8'h00, 1'b0},
    '{40'h43695A0000, 3'd3, 4'h9, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h5A, 1'b0},
    '{40'h2E03000000, 3'd2, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h03, 1'b0},
    '{40'h3E0F200000, 3'd4, 4'h0, 4'h0, 4'h0, 16'h2000, 24'h000000, 8'h0F, 1'b0},
    '{40'h09FE000000, 3'd2, 4'hE, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b0},
    '{40'h0C00000000, 3'd1, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b1},
    '{40'h4700000000, 3'd1, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b1},
    '{40'h1152340000, 3'd3, 4'h2, 4'h4, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b0},
    '{40'h2500000000, 3'd1, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b0},
    '{40'h39F1ABCDEF, 3'd5, 4'h1, 4'h0, 4'h0, 16'h0000, 24'hABCDEF, 8'h00, 1'b0},
    '{40'hFF00000000, 3'd1, 4'h0, 4'h0, 4'h0, 16'h0000, 24'h000000, 8'h00, 1'b1}
  };

  ifetch_top u_dut (
    .clk, .rst_n, .redirect, .redirect_pc, .mem_rd_en, .mem_addr, .mem_rdata,
    .out_valid, .out_ready, .out_pc, .out_op, .out_len, .out_ra, .out_rb,
    .out_rc, .out_imm16, .out_addr24, .out_byte8, .out_illegal
  );

  always #4 clk = ~clk;

  always @(posedge clk)
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!out_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R5 bundle arrives", 32'(out_valid), 32'd1);
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_redirect(logic [15:0] a);
    redirect = 1'b1;
    redirect_pc = a;
    @(negedge clk);
    redirect = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pc;
    logic [7:0]  op0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    pc = 16'h0100;
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VECS[v].len); k++)
        mem[pc[9:0] + 10'(k)] = VECS[v].b[39 - 8*k -: 8];
      pc = pc + 16'(VECS[v].len);
    end
    mem[10'h200] = 8'h1C; mem[10'h201] = 8'h03; mem[10'h202] = 8'h04;
    mem[10'h203] = 8'h55; mem[10'h204] = 8'h66;
    mem[10'h300] = 8'h43; mem[10'h301] = 8'h0B; mem[10'h302] = 8'hC3;

    repeat (3) @(negedge clk);
    chk("R10 valid low in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    #1;
    chk("R10 first read strobe", 32'(mem_rd_en), 32'd1);
    chk("R10 first read address", 32'(mem_addr), 32'h0100);

    pc = 16'h0100;
    for (int v = 0; v < NV; v++) begin
      wait_valid();
      op0 = out_op;
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        chk("R6 valid held", 32'(out_valid), 32'd1);
        chk("R6 no read while held", 32'(mem_rd_en), 32'd0);
        chk("R6 opcode stable", 32'(out_op), 32'(op0));
      end
      chk("R1 opcode", 32'(out_op), 32'(VECS[v].b[39:32]));
      chk("R1 length", 32'(out_len), 32'(VECS[v].len));
      chk("R5 start pc", 32'(out_pc), 32'(pc));
      chk("R3 ra", 32'(out_ra), 32'(VECS[v].ra));
      chk("R3 rb", 32'(out_rb), 32'(VECS[v].rb));
      chk("R9 rc", 32'(out_rc), 32'(VECS[v].rc));
      chk("R2 imm16", 32'(out_imm16), 32'(VECS[v].imm));
      chk("R2 addr24", 32'(out_addr24), 32'(VECS[v].a24));
      chk("R2 byte8", 32'(out_byte8), 32'(VECS[v].b8));
      chk("R4 illegal flag", 32'(out_illegal), 32'(VECS[v].ill));
      pc = pc + 16'(VECS[v].len);
      accept();
    end

    // R7: redirect while the 5-byte instruction at 0x200 is half fetched
    @(negedge clk);
    do_redirect(16'h0200);
    chk("R8 read at redirect target", 32'(mem_addr), 32'h0200);
    chk("R8 read strobe after redirect", 32'(mem_rd_en), 32'd1);
    repeat (4) @(negedge clk);
    do_redirect(16'h0300);
    wait_valid();
    chk("R7 opcode after mid redirect", 32'(out_op), 32'h43);
    chk("R7 pc after mid redirect", 32'(out_pc), 32'h0300);
    chk("R7 length after mid redirect", 32'(out_len), 32'd3);
    chk("R2 byte8 after redirect", 32'(out_byte8), 32'hC3);
    chk("R3 ra after redirect", 32'(out_ra), 32'hB);

    // R7: redirect while a bundle is held
    do_redirect(16'h0200);
    chk("R7 valid dropped", 32'(out_valid), 32'd0);
    wait_valid();
    chk("R7 opcode at 0x200", 32'(out_op), 32'h1C);
    chk("R7 pc at 0x200", 32'(out_pc), 32'h0200);
    chk("R2 branch target", 32'(out_imm16), 32'h5566);
    chk("R2 branch rb", 32'(out_rb), 32'h4);
    accept();
    wait_valid();
    chk("R5 pc after 5-byte", 32'(out_pc), 32'h0205);
    chk("R1 stop length", 32'(out_len), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule